// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits behind the serial command decoder of a flash memory and carries out the three write-class operations: page program, sector erase and whole-array erase. The decoder hands it a one-cycle request with an operation code and a byte address. For a program request it then forwards each data byte from the bus as a one-cycle write strobe. When chip select returns high, the decoder raises a one-cycle start strobe. The sequencer then counts out a busy period whose length depends on the operation. After that it walks the target range through a byte-wide storage port, and it reports the result in an 8-bit status byte.

The block holds the page buffer. Each buffer slot carries a loaded flag, so only the bytes that were actually sent get written back. Programming can only clear bits: the stored value becomes the old value ANDed with the buffered value. A loaded byte that asks for any 0-to-1 change raises a sticky program-error flag. While either error flag is set, every new program or erase request is turned away. A separate clear strobe resets both error flags.

Top module: `flash_pe_seq`

## Requirements
- R1: The status byte has the completion flag in bit 7, the erase-error flag in bit 4, the program-error flag in bit 3 and ready (1) / busy (0) in bit 0. Bits 6, 5, 2 and 1 always read 0.
- R2: After reset the status byte reads 81h.
- R3: An accepted request sets bit 7 in the following cycle, and ready stays 1 until the start strobe. When the operation finishes, bit 7 returns to 0 and ready returns to 1.
- R4: Counted from the cycle after the start strobe, ready stays low for exactly the operation's cycle count plus the number of bytes in its target range. The cycle counts are PROG_CYC, SERASE_CYC and CERASE_CYC. The ranges are one page, one sector and the whole array.
- R5: A clear strobe resets bits 4 and 3, sets bit 7, and leaves bit 0 unchanged.
- R6: While bit 4 or bit 3 is set, a request is refused. The status byte does not change, the start strobe that follows does nothing, and the storage is not written.
- R7: Operation code 01b is page program. Data bytes fill the buffer starting at the page offset given in the low PAGE_W address bits, and the pointer wraps to offset 0 after the last offset. A later byte at an offset replaces an earlier one. Only loaded offsets of the page are written.
- R8: A programmed location receives the old value ANDed with the buffered byte. If the buffered byte has a 1 where the old value has a 0, bit 3 becomes 1.
- R9: Operation code 10b is sector erase. It writes FFh to every byte of the 2^SECT_W-byte sector selected by the address bits above SECT_W, and leaves all other bytes unchanged.
- R10: Operation code 11b is whole-array erase. It ignores the address and writes FFh to every location.
- R11: The block ignores a request with operation code 00b, a request that arrives while an operation is open or busy, and a start strobe that arrives while no operation is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle request strobe |
| cmd_op | input | 2 | Operation code: 01 program, 10 sector erase, 11 array erase |
| cmd_addr | input | ADDR_W | Byte address of the request |
| wr_valid | input | 1 | Buffer write strobe during a program transaction |
| wr_data | input | 8 | Buffer write data |
| cs_rise | input | 1 | One-cycle strobe marking the end of the transaction (start) |
| clr_stat | input | 1 | One-cycle clear of the error flags |
| status | output | 8 | Status byte |
| mem_we | output | 1 | Storage write enable |
| mem_addr | output | ADDR_W | Storage address (read and write) |
| mem_wdata | output | 8 | Storage write data |
| mem_rdata | input | 8 | Storage read data at mem_addr, same cycle |

## Verification
The assertions take for granted that every strobe lasts a single cycle and that clear, request and start never coincide. They also assume the storage returns the byte at mem_addr in the same cycle. Under those conditions the status byte can stay constant across a refused request. The stimulus issues each strobe on its own falling clock edge, separates the strobes by at least one idle cycle, and models the storage as a combinational-read array that the bench owns.

// File: rtl/flash_seq_pkg.sv
// Shared types for the program/erase sequencer.
// Assumes: operation codes arrive from the command decoder already decoded to 2 bits.
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_PROG   = 2'b01,
        OP_SERASE = 2'b10,
        OP_CERASE = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ARMED,
        ST_WAIT,
        ST_WALK
    } seq_st_e;

endpackage

// File: rtl/seq_page_buf.sv
// Page buffer with one loaded flag per byte and a wrapping write pointer.
// Assumes: open_i and wr_i never arrive in the same cycle.
module seq_page_buf #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic [PAGE_W-1:0] start_off_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_loaded_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded_q;
    logic [PAGE_W-1:0]     ptr_q;

    // Track the loaded slots and advance the pointer, wrapping within the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= '0;
            ptr_q    <= '0;
        end else if (open_i) begin
            loaded_q <= '0;
            ptr_q    <= start_off_i;
        end else if (wr_i) begin
            loaded_q[ptr_q] <= 1'b1;
            ptr_q           <= ptr_q + 1'b1;
        end
    end

    // Store the byte at the pointer; a later write to a slot replaces the earlier one.
    always_ff @(posedge clk) begin
        if (wr_i && !open_i) begin
            data_q[ptr_q] <= wdata_i;
        end
    end

    assign rd_data_o   = data_q[rd_idx_i];
    assign rd_loaded_o = loaded_q[rd_idx_i];

endmodule

// File: rtl/seq_timer.sv
// Down-counter that stands in for the physical program/erase pulse time.
// Assumes: the load value is the wanted cycle count minus one.
module seq_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= load_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/seq_status.sv
// Status byte: completion, sticky error flags and ready/busy.
// Assumes: clear takes precedence over a same-cycle finish or error.
module seq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       start_i,
    input  logic       finish_i,
    input  logic       clr_i,
    input  logic       perr_set_i,
    input  logic       eerr_set_i,
    output logic [7:0] status_o
);
    logic done_q, eerr_q, perr_q, busy_q;

    // Update the flags from the sequencer events; a later statement wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
            eerr_q <= 1'b0;
            perr_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (accept_i)   done_q <= 1'b1;
            if (start_i)    busy_q <= 1'b1;
            if (finish_i) begin
                done_q <= 1'b0;
                busy_q <= 1'b0;
            end
            if (perr_set_i) perr_q <= 1'b1;
            if (eerr_set_i) eerr_q <= 1'b1;
            if (clr_i) begin
                done_q <= 1'b1;
                perr_q <= 1'b0;
                eerr_q <= 1'b0;
            end
        end
    end

    assign status_o = {done_q, 2'b00, eerr_q, perr_q, 2'b00, ~busy_q};

endmodule

// File: rtl/flash_pe_seq.sv
// Program/erase sequencer: accepts a request, buffers program data, runs a
// timed busy period after the start strobe, then walks the target range
// through the storage port and reports the result in the status byte.
// Assumes: one-cycle strobes from the command decoder; combinational storage read.
module flash_pe_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_W     = 7,
    parameter int SECT_W     = 13,
    parameter int PROG_CYC   = 250000,
    parameter int SERASE_CYC = 15000000,
    parameter int CERASE_CYC = 15000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              cs_rise,
    input  logic              clr_stat,
    output logic [7:0]        status,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int SECT_BYTES = 1 << SECT_W;
    localparam int MAX_ER     = (SERASE_CYC > CERASE_CYC) ? SERASE_CYC : CERASE_CYC;
    localparam int MAX_CYC    = (PROG_CYC > MAX_ER) ? PROG_CYC : MAX_ER;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    seq_st_e           st_q;
    op_e               op_q;
    op_e               cmd_op_e;
    logic [ADDR_W-1:0] base_q, last_q, idx_q;
    logic [ADDR_W-1:0] next_base, next_last;
    logic [CNT_W-1:0]  tmr_load;
    logic              seq_idle, is_prog, err_any;
    logic              accept, start, walking, finish;
    logic              tmr_zero, buf_loaded, perr_set;
    logic [7:0]        buf_data;

    assign cmd_op_e = op_e'(cmd_op);
    assign seq_idle = (st_q == ST_IDLE);
    assign is_prog  = (op_q == OP_PROG);
    assign err_any  = status[4] | status[3];
    assign accept   = cmd_valid && seq_idle && !err_any && (cmd_op_e != OP_NONE);
    assign start    = cs_rise && ((st_q == ST_LOAD) || (st_q == ST_ARMED));
    assign walking  = (st_q == ST_WALK);
    assign finish   = walking && (idx_q == last_q);

    // Base address and last walk index of the requested range.
    always_comb begin
        case (cmd_op_e)
            OP_PROG: begin
                next_base = {cmd_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
                next_last = ADDR_W'(PAGE_BYTES - 1);
            end
            OP_SERASE: begin
                next_base = {cmd_addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
                next_last = ADDR_W'(SECT_BYTES - 1);
            end
            default: begin
                next_base = '0;
                next_last = '1;
            end
        endcase
    end

    // Busy length of the latched operation, minus one for the timer.
    always_comb begin
        case (op_q)
            OP_PROG:   tmr_load = CNT_W'(PROG_CYC - 1);
            OP_SERASE: tmr_load = CNT_W'(SERASE_CYC - 1);
            default:   tmr_load = CNT_W'(CERASE_CYC - 1);
        endcase
    end

    // Main sequence: idle, load or armed, timed wait, storage walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_NONE;
            base_q <= '0;
            last_q <= '0;
            idx_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    op_q   <= cmd_op_e;
                    base_q <= next_base;
                    last_q <= next_last;
                    st_q   <= (cmd_op_e == OP_PROG) ? ST_LOAD : ST_ARMED;
                end
                ST_LOAD, ST_ARMED: if (start) st_q <= ST_WAIT;
                ST_WAIT: if (tmr_zero) begin
                    idx_q <= '0;
                    st_q  <= ST_WALK;
                end
                ST_WALK: begin
                    idx_q <= idx_q + 1'b1;
                    if (finish) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    seq_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (accept && (cmd_op_e == OP_PROG)),
        .start_off_i (cmd_addr[PAGE_W-1:0]),
        .wr_i        (wr_valid && (st_q == ST_LOAD)),
        .wdata_i     (wr_data),
        .rd_idx_i    (idx_q[PAGE_W-1:0]),
        .rd_data_o   (buf_data),
        .rd_loaded_o (buf_loaded)
    );

    seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .load_i  (tmr_load),
        .zero_o  (tmr_zero)
    );

    assign perr_set = walking && is_prog && buf_loaded && ((buf_data & ~mem_rdata) != 8'h00);

    seq_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .start_i    (start),
        .finish_i   (finish),
        .clr_i      (clr_stat),
        .perr_set_i (perr_set),
        .eerr_set_i (1'b0),
        .status_o   (status)
    );

    assign mem_addr  = base_q + idx_q;
    assign mem_we    = walking && (!is_prog || buf_loaded);
    assign mem_wdata = is_prog ? (buf_data & mem_rdata) : 8'hFF;

endmodule

// File: rtl/flash_pe_seq_chk.sv
// Property checker for the sequencer, bound to every instance of the top.
// Assumes: single-cycle, non-overlapping strobes from the command decoder.
module flash_pe_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       cs_rise,
    input logic       clr_stat,
    input logic [7:0] status,
    input logic       mem_we,
    input logic [7:0] mem_wdata,
    input logic [7:0] mem_rdata,
    input logic       is_prog,
    input logic       in_idle
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00 && status[2:1] == 2'b00);

    // R2
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> status == 8'h81);

    // R3
    accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && in_idle && !status[4] && !status[3] && cmd_op != 2'b00 |=> status[7]);

    // R3
    finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) && !$past(clr_stat) |-> !status[7]);

    // R5
    clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> status[7] && !status[4] && !status[3]);

    // R6
    refuse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !clr_stat && !cs_rise && status[0] && (status[4] || status[3]) |=> $stable(status));

    // R8
    prog_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && is_prog |-> (mem_wdata & ~mem_rdata) == 8'h00);

    // R4
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !status[0]);

    // R11
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> status[0]);

endmodule

bind flash_pe_seq flash_pe_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cs_rise   (cs_rise),
    .clr_stat  (clr_stat),
    .status    (status),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .is_prog   (is_prog),
    .in_idle   (seq_idle)
);

// File: tb/sim_flash_pe_seq.sv
// Bench for the sequencer on a small array: 256 bytes, 8-byte pages, 32-byte sectors.
module sim_flash_pe_seq;
    localparam int AW = 8;
    localparam int PW = 3;
    localparam int SW = 5;
    localparam int PC = 5;
    localparam int SC = 9;
    localparam int CC = 12;
    localparam int NB = 1 << AW;
    localparam int PB = 1 << PW;
    localparam int SB = 1 << SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          cs_rise = 1'b0;
    logic          clr_stat = 1'b0;
    logic [7:0]    status;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;

    logic [7:0] arr   [NB];
    logic [7:0] exp_m [NB];
    logic [7:0] bbuf  [PB];
    logic       bld   [PB];

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (mem_we) arr[mem_addr] <= mem_wdata;
    assign mem_rdata = arr[mem_addr];

    flash_pe_seq #(
        .ADDR_W(AW), .PAGE_W(PW), .SECT_W(SW),
        .PROG_CYC(PC), .SERASE_CYC(SC), .CERASE_CYC(CC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data),
        .cs_rise(cs_rise), .clr_stat(clr_stat), .status(status),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic chkn(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_cs();
        @(negedge clk);
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_stat = 1'b1;
        @(negedge clk);
        clr_stat = 1'b0;
    endtask

    task automatic wait_ready(output int busy);
        busy = 0;
        while (status[0] == 1'b0 && busy < 20000) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic check_mem(input string tag);
        for (int i = 0; i < NB; i++) chk8(tag, arr[i], exp_m[i]);
    endtask

    // Program one page: n bytes from offset, expected result built from the buffer model.
    task automatic prog_page(input int page, input int off, input int n, input int seed,
                             input logic [7:0] fixed, input bit use_fixed, output bit experr);
        int busy;
        for (int i = 0; i < PB; i++) bld[i] = 1'b0;
        send_cmd(2'b01, AW'(page * PB + off));
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = use_fixed ? fixed : 8'((seed * 37 + i * 11 + 3) & 255);
            bbuf[(off + i) % PB] = d;
            bld[(off + i) % PB]  = 1'b1;
            push(d);
        end
        experr = 1'b0;
        for (int i = 0; i < PB; i++) begin
            if (bld[i]) begin
                if ((bbuf[i] & ~exp_m[page * PB + i]) != 8'h00) experr = 1'b1;
                exp_m[page * PB + i] = bbuf[i] & exp_m[page * PB + i];
            end
        end
        pulse_cs();
        wait_ready(busy);
        chkn("R4 program busy cycles", busy, PC + PB);
    endtask

    initial begin
        int busy;
        bit e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk8("R2 reset status", status, 8'h81);

        // R11: start strobe with nothing open does nothing
        pulse_cs();
        chk8("R11 idle start ignored", status, 8'h81);

        // R10: whole-array erase
        send_cmd(2'b11, 8'h37);
        chk8("R3 accepted, still ready", status, 8'h81);
        pulse_cs();
        chk8("R3 busy after start", status, 8'h80);
        wait_ready(busy);
        chkn("R4 array erase busy cycles", busy, CC + NB);
        chk8("R3 finished status", status, 8'h01);
        for (int i = 0; i < NB; i++) exp_m[i] = 8'hFF;
        check_mem("R10 array erased");

        // R7: sweep over pages, offsets and byte counts, including wrap and overwrite
        for (int p = 0; p < NB / PB; p++) begin
            int n;
            n = (p == NB / PB - 1) ? PB + 3 : (p % PB) + 1;
            prog_page(p, p % PB, n, p, 8'h00, 1'b0, e);
            chk8("R7 program status", status, e ? 8'h09 : 8'h01);
        end
        check_mem("R7 page contents");

        // R8: subset data gives AND result and no error
        prog_page(1, 2, 1, 0, exp_m[PB + 2] & 8'h0F, 1'b1, e);
        chk8("R8 subset program status", status, 8'h01);
        // R8: data needing a 0-to-1 change raises the program error
        prog_page(0, 0, 1, 0, 8'hFF, 1'b1, e);
        chkn("R8 bench expects error", int'(e), 1);
        chk8("R8 error status", status, 8'h09);
        check_mem("R8 contents after AND");

        // R6: refused requests while the error flag is set
        send_cmd(2'b10, 8'h00);
        chk8("R6 refused erase status", status, 8'h09);
        pulse_cs();
        chk8("R6 start after refusal", status, 8'h09);
        send_cmd(2'b01, 8'h10);
        push(8'h00);
        pulse_cs();
        repeat (PC + PB + 4) @(negedge clk);
        chk8("R6 refused program status", status, 8'h09);
        check_mem("R6 storage untouched");

        // R5: clear
        pulse_clr();
        chk8("R5 clear status", status, 8'h81);

        // R9: sector erase
        send_cmd(2'b10, 8'h6A);
        pulse_cs();
        wait_ready(busy);
        chkn("R4 sector erase busy cycles", busy, SC + SB);
        chk8("R9 sector status", status, 8'h01);
        for (int i = 3 * SB; i < 4 * SB; i++) exp_m[i] = 8'hFF;
        check_mem("R9 sector contents");

        // R11: code 00 ignored, requests and start strobes while busy ignored
        send_cmd(2'b00, 8'h00);
        chk8("R11 code 00 ignored", status, 8'h01);
        send_cmd(2'b10, 8'h05);
        pulse_cs();
        send_cmd(2'b11, 8'h00);
        pulse_cs();
        wait_ready(busy);
        chk8("R11 status after busy requests", status, 8'h01);
        for (int i = 0; i < SB; i++) exp_m[i] = 8'hFF;
        check_mem("R11 only sector 0 erased");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule